// File: doc/BRIEF.md
# Capture Stream Run-Length Encoder

This block sits between a sampling front end and on-chip sample memory. It takes fixed-width samples, each qualified by a valid strobe. It produces storage words that are one bit wider than a sample, and each storage word has its own valid strobe. When compression is enabled, a sample that equals the one before it is not stored again. Instead, an internal counter grows, and the block later writes a single repeat-count word that says how many more times the stored sample occurred. A long run of identical samples is cut into several count words, because one count word can hold at most `RUN_LEN-1` repeats.

Compression is chosen at run time through `rle_en`. When `rle_en` is low, every valid sample is stored as a raw word. When a capture ends, `flush` pushes out a count that is still waiting. The memory depth is measured in storage words, so a full memory can decode to more samples than it has entries. Sometimes one input cycle must produce two words: a pending count followed by a new raw sample. A one-word holding slot inside the block absorbs the second word. No input is ever refused, so the block has no ready signal.

Top module: `rle_capture_encoder`

## Requirements
- R1: A storage word is `SAMPLE_W+1` bits wide, and bit `SAMPLE_W` is the marker. Marker 0 means bits `SAMPLE_W-1:0` hold a raw sample. Marker 1 means the low bits hold an unsigned, zero-extended count of how many more times the previous raw sample repeats.
- R2: With `rle_en` high, the first valid sample of a run is stored as a raw word. A run starts after reset, after `rle_en` was low, or when the sample differs from the previous one. Later identical samples emit nothing until a count word is due.
- R3: A count word never exceeds `RUN_LEN-1`. When the pending count reaches `RUN_LEN-1`, the count word is emitted at once and the counter restarts at zero. Further identical samples are then counted again without a new raw word.
- R4: A run of N identical samples, closed by a differing sample or by `flush`, produces exactly 1 + ceil((N-1)/(`RUN_LEN`-1)) words. With `RUN_LEN`=256, a 256-sample run gives 2 words and a 1024-sample run gives 6 words.
- R5: When every sample differs from the one before it, each sample yields exactly one raw word, and the words keep the input order.
- R6: With `rle_en` low, every valid sample is stored as a raw word and no count word is produced.
- R7: A differing sample that arrives while a count is pending produces the count word first. Its raw word appears on the next output cycle.
- R8: Each word appears on `out_word` one cycle after the input cycle that caused it, unless earlier words are still waiting. No sample is lost under a valid strobe held high continuously.
- R9: `flush` with `rle_en` high emits the pending count as a count word, including a valid repeat that arrives in the same cycle. `flush` with nothing pending emits nothing. The run's sample is kept, so a following identical sample is counted without a raw word.
- R10: Driving `rle_en` low, or asserting reset, discards the run state along with any pending count. The next sample with `rle_en` high is stored raw.
- R11: While reset is asserted, and when it is released, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; it is released synchronously inside the block |
| rle_en | input | 1 | Compression enable; when low, samples pass through as raw words |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Captured sample |
| flush | input | 1 | End-of-capture request that forces out a pending count |
| out_valid | output | 1 | Storage word strobe |
| out_word | output | SAMPLE_W+1 | Storage word; the top bit is the marker |

## Verification
The bench targets the runs that straddle the saturation point. A design that emitted only at `RUN_LEN` repeats, or that wrote a fresh raw word after each count word, would miss the 2-word and 6-word totals for the 256-sample and 1024-sample runs. Alternating runs of two keep the count-then-raw pair colliding with the next raw word. A design without the holding slot, or with the slot drained in the wrong order, would drop or reorder words. Other cases cover a flush that coincides with a repeat, and an enable drop or a reset in the middle of a run. A design that kept stale run state would output a count word where a raw word is expected.

// File: rtl/rle_enc_pkg.sv
package rle_enc_pkg;

  // Marker values carried in the top bit of every storage word.
  localparam logic MARK_RAW   = 1'b0;
  localparam logic MARK_COUNT = 1'b1;

  // What a single input cycle asks the output side to store.
  typedef enum logic [1:0] {
    EV_NONE      = 2'd0,
    EV_RAW       = 2'd1,
    EV_COUNT     = 2'd2,
    EV_COUNT_RAW = 2'd3
  } run_evt_e;

endpackage

// File: rtl/rle_rst_sync.sv
module rle_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage1_q;
  logic stage2_q;

  // Two-flop release: asserts immediately, de-asserts on the second clock edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;

endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
  import rle_enc_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int RUN_LEN  = 256,
  parameter int CNT_W    = $clog2(RUN_LEN),
  parameter int WORD_W   = SAMPLE_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rle_en,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                flush,
  output logic                e0_v,
  output logic [WORD_W-1:0]   e0_w,
  output logic                e1_v,
  output logic [WORD_W-1:0]   e1_w
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(RUN_LEN - 1);

  logic                have_q, have_d;
  logic [SAMPLE_W-1:0] last_q, last_d;
  logic                last_en;
  logic [CNT_W-1:0]    cnt_q, cnt_d;
  logic [CNT_W-1:0]    cnt_inc;
  logic [CNT_W-1:0]    cnt_out;
  logic [SAMPLE_W-1:0] cnt_ext;
  logic                same;
  run_evt_e            evt;

  assign same    = have_q && (in_sample == last_q);
  assign cnt_inc = cnt_q + 1'b1;

  // Next-state and event decision.
  always_comb begin
    have_d  = have_q;
    last_d  = last_q;
    last_en = 1'b0;
    cnt_d   = cnt_q;
    cnt_out = cnt_q;
    evt     = EV_NONE;
    if (!rle_en) begin
      have_d = 1'b0;
      cnt_d  = '0;
      if (in_valid) evt = EV_RAW;
    end else if (in_valid) begin
      if (!same) begin
        evt     = (cnt_q != '0) ? EV_COUNT_RAW : EV_RAW;
        have_d  = 1'b1;
        last_d  = in_sample;
        last_en = 1'b1;
        cnt_d   = '0;
      end else if ((cnt_inc == CNT_MAX) || flush) begin
        evt     = EV_COUNT;
        cnt_out = cnt_inc;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_inc;
      end
    end else if (flush && (cnt_q != '0)) begin
      evt   = EV_COUNT;
      cnt_d = '0;
    end
  end

  // Zero-extend the count into the sample field.
  always_comb begin
    cnt_ext              = '0;
    cnt_ext[CNT_W-1:0]   = cnt_out;
  end

  // Map the event onto up to two ordered storage words.
  always_comb begin
    e0_v = (evt != EV_NONE);
    e1_v = (evt == EV_COUNT_RAW);
    e1_w = {MARK_RAW, in_sample};
    if (evt == EV_RAW) e0_w = {MARK_RAW, in_sample};
    else               e0_w = {MARK_COUNT, cnt_ext};
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
    end else begin
      have_q <= have_d;
      cnt_q  <= cnt_d;
      if (last_en) last_q <= last_d;
    end
  end

  // Pending count stays within one count word.
  assert_cnt_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_MAX);

  // A double emission is always count first, then raw.
  assert_pair_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    e1_v |-> (e0_v && (e0_w[SAMPLE_W] == MARK_COUNT) && (e1_w[SAMPLE_W] == MARK_RAW)));

  // Passthrough mode never produces a count word.
  assert_disabled_raw_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rle_en && e0_v) |-> ((e0_w[SAMPLE_W] == MARK_RAW) && !e1_v));

  // A flush leaves nothing pending.
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rle_en && flush) |=> (cnt_q == '0));

  // Disabling forgets the run.
  assert_disable_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rle_en |=> ((cnt_q == '0) && !have_q));

endmodule

// File: rtl/rle_emit_slot.sv
module rle_emit_slot #(
  parameter int WORD_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              e0_v,
  input  logic [WORD_W-1:0] e0_w,
  input  logic              e1_v,
  input  logic [WORD_W-1:0] e1_w,
  output logic              out_v,
  output logic [WORD_W-1:0] out_w
);

  logic              hold_v_q;
  logic [WORD_W-1:0] hold_w_q;
  logic              out_v_q;
  logic [WORD_W-1:0] out_w_q;

  logic              first_v, second_v;
  logic [WORD_W-1:0] first_w, second_w;

  // Oldest word leaves first; the next one waits in the hold slot.
  always_comb begin
    if (hold_v_q) begin
      first_v  = 1'b1;
      first_w  = hold_w_q;
      second_v = e0_v;
      second_w = e0_w;
    end else begin
      first_v  = e0_v;
      first_w  = e0_w;
      second_v = e1_v;
      second_w = e1_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_v_q  <= 1'b0;
      out_w_q  <= '0;
      hold_v_q <= 1'b0;
      hold_w_q <= '0;
    end else begin
      out_v_q  <= first_v;
      hold_v_q <= second_v;
      if (first_v)  out_w_q  <= first_w;
      if (second_v) hold_w_q <= second_w;
    end
  end

  assign out_v = out_v_q;
  assign out_w = out_w_q;

  // A third word in flight would be lost.
  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(hold_v_q && e1_v));

  // A held word only exists behind a word already presented.
  assert_hold_behind_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_v_q |-> out_v_q);

endmodule

// File: rtl/rle_capture_encoder.sv
module rle_capture_encoder #(
  parameter int SAMPLE_W = 8,
  parameter int RUN_LEN  = 256
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rle_en,
  input  logic                in_valid,
  input  logic [SAMPLE_W-1:0] in_sample,
  input  logic                flush,
  output logic                out_valid,
  output logic [SAMPLE_W:0]   out_word
);

  localparam int WORD_W = SAMPLE_W + 1;
  localparam int CNT_W  = $clog2(RUN_LEN);

  logic              rst_sync_n;
  logic              e0_v, e1_v;
  logic [WORD_W-1:0] e0_w, e1_w;

  rle_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rle_run_tracker #(
    .SAMPLE_W (SAMPLE_W),
    .RUN_LEN  (RUN_LEN),
    .CNT_W    (CNT_W),
    .WORD_W   (WORD_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .rle_en    (rle_en),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .flush     (flush),
    .e0_v      (e0_v),
    .e0_w      (e0_w),
    .e1_v      (e1_v),
    .e1_w      (e1_w)
  );

  rle_emit_slot #(
    .WORD_W (WORD_W)
  ) u_slot (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .e0_v  (e0_v),
    .e0_w  (e0_w),
    .e1_v  (e1_v),
    .e1_w  (e1_w),
    .out_v (out_valid),
    .out_w (out_word)
  );

  // Output is quiet on the edge where the internal reset lets go.
  assert_reset_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_sync_n) |-> !out_valid);

endmodule

// File: tb/sim_rle_capture_encoder.sv
module sim_rle_capture_encoder;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int RL = 256;
  localparam int WW = SW + 1;

  logic          clk;
  logic          rst_n;
  logic          rle_en;
  logic          in_valid;
  logic [SW-1:0] in_sample;
  logic          flush;
  logic          out_valid;
  logic [WW-1:0] out_word;

  int checks;
  int fails;
  int cyc;
  int win_words;

  // Reference model state.
  bit            m_have;
  logic [SW-1:0] m_last;
  int            m_cnt;
  logic [WW-1:0] q[$];

  rle_capture_encoder #(.SAMPLE_W(SW), .RUN_LEN(RL)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .rle_en    (rle_en),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .flush     (flush),
    .out_valid (out_valid),
    .out_word  (out_word)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected < 100000", cyc);
      summary();
    end
  end

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic push_cnt(int c);
    q.push_back({1'b1, SW'(c)});
  endtask

  // One clock: drive, update model at the edge, compare at the next falling edge.
  task automatic step(bit v, logic [SW-1:0] s, bit en, bit fl, string tag);
    bit            exp_v;
    logic [WW-1:0] exp_w;
    in_valid  = v;
    in_sample = s;
    rle_en    = en;
    flush     = fl;
    @(posedge clk);
    if (!en) begin
      m_have = 0;
      m_cnt  = 0;
      if (v) q.push_back({1'b0, s});
    end else if (v) begin
      if (!m_have || s != m_last) begin
        if (m_cnt != 0) push_cnt(m_cnt);
        q.push_back({1'b0, s});
        m_have = 1;
        m_last = s;
        m_cnt  = 0;
      end else begin
        m_cnt++;
        if (m_cnt == RL - 1 || fl) begin
          push_cnt(m_cnt);
          m_cnt = 0;
        end
      end
    end else if (fl && m_cnt != 0) begin
      push_cnt(m_cnt);
      m_cnt = 0;
    end
    exp_v = 0;
    exp_w = '0;
    if (q.size() > 0) begin
      exp_v = 1;
      exp_w = q.pop_front();
    end
    @(negedge clk);
    if (out_valid) win_words++;
    if (exp_v)
      chk(out_valid === 1'b1 && out_word === exp_w, tag, "word", {out_valid, out_word}, {1'b1, exp_w});
    else
      chk(out_valid === 1'b0, tag, "idle", out_valid, 0);
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, '0, 1, 0, tag);
  endtask

  task automatic do_reset(string tag);
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 0; flush = 0;
    m_have = 0; m_cnt = 0; q.delete();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid === 1'b0, tag, "reset out_valid", out_valid, 0);
    end
    rst_n = 1'b1;
    idle(3, tag);
  endtask

  initial begin
    checks = 0; fails = 0; cyc = 0; win_words = 0;
    m_have = 0; m_cnt = 0; m_last = '0;
    rst_n = 1'b0; rle_en = 0; in_valid = 0; in_sample = '0; flush = 0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R11", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    idle(3, "R11");

    // R6: passthrough with compression off, repeats included.
    step(1, 8'h05, 0, 0, "R6");
    step(1, 8'h05, 0, 0, "R6");
    step(1, 8'h05, 0, 0, "R6");
    step(1, 8'h07, 0, 1, "R6");
    idle(2, "R6");

    // R2: first sample after enabling is raw; repeats stay silent.
    step(1, 8'h05, 1, 0, "R2");
    step(1, 8'h05, 1, 0, "R2");
    step(1, 8'h05, 1, 0, "R2");
    step(0, '0, 1, 1, "R2");
    idle(2, "R2");

    // R5: all-distinct stream.
    for (int i = 0; i < 20; i++) step(1, SW'(i + 16), 1, 0, "R5");
    idle(2, "R5");

    // R1: A A A A B gives raw A, count 3, raw B.
    for (int i = 0; i < 4; i++) step(1, 8'hA0, 1, 0, "R1");
    step(1, 8'hB0, 1, 0, "R1");
    idle(3, "R1");

    // R7: pairs back to back, count/raw collisions every other cycle.
    for (int i = 0; i < 30; i++) begin
      step(1, SW'(8'h40 + i), 1, 0, "R7");
      step(1, SW'(8'h40 + i), 1, 0, "R7");
    end
    step(0, '0, 1, 1, "R7");
    idle(3, "R7");

    // R4 / R3: 256-sample run, closed by flush.
    step(1, 8'h11, 1, 1, "R4");
    idle(3, "R4");
    win_words = 0;
    for (int i = 0; i < 256; i++) step(1, 8'h22, 1, 0, "R3");
    step(0, '0, 1, 1, "R4");
    idle(3, "R4");
    chk(win_words == 2, "R4", "256-run words", win_words, 2);

    // R4 / R3: 1024-sample run.
    win_words = 0;
    for (int i = 0; i < 1024; i++) step(1, 8'h33, 1, 0, "R3");
    step(0, '0, 1, 1, "R4");
    idle(3, "R4");
    chk(win_words == 6, "R4", "1024-run words", win_words, 6);

    // R9: flush with a repeat, empty flush, run continues without raw.
    step(1, 8'h44, 1, 0, "R9");
    step(1, 8'h44, 1, 0, "R9");
    step(1, 8'h44, 1, 1, "R9");
    step(0, '0, 1, 1, "R9");
    win_words = 0;
    step(1, 8'h44, 1, 0, "R9");
    step(1, 8'h44, 1, 0, "R9");
    idle(2, "R9");
    chk(win_words == 0, "R9", "no raw after flush", win_words, 0);
    step(0, '0, 1, 1, "R9");
    idle(2, "R9");

    // R10: enable drop discards a pending count.
    step(1, 8'h55, 1, 0, "R10");
    step(1, 8'h55, 1, 0, "R10");
    step(1, 8'h55, 1, 0, "R10");
    step(0, '0, 0, 0, "R10");
    step(1, 8'h55, 1, 0, "R10");
    step(0, '0, 1, 1, "R10");
    idle(2, "R10");

    // R10 / R11: reset in the middle of a run.
    step(1, 8'h66, 1, 0, "R10");
    step(1, 8'h66, 1, 0, "R10");
    do_reset("R11");
    step(1, 8'h66, 1, 0, "R10");
    step(0, '0, 1, 1, "R10");
    idle(2, "R10");

    // R8: dense pseudo-random stream over a tiny alphabet.
    for (int i = 0; i < 3000; i++) begin
      bit v, fl, en;
      v  = ($urandom % 4) != 0;
      fl = ($urandom % 32) == 0;
      en = ($urandom % 64) != 0;
      step(v, SW'($urandom % 3), en, fl, "R8");
    end
    step(0, '0, 1, 1, "R8");
    idle(4, "R8");

    summary();
  end

endmodule